// File: doc/BRIEF.md
# Orderly Halt Sequencer

This block sits beside a script-driven DMA and bus engine. It decides when that engine may stop after an interrupt request. When a request arrives while the engine is running, the sequencer takes a snapshot of what the engine is doing. That snapshot covers five things: an instruction fetch, a control-flow instruction in execution, a DMA transfer and its direction, a bus request/acknowledge handshake, and an outstanding synchronous offset. From the snapshot it opens one wait slot for each activity that must be carried to a clean end before stopping.

Each slot closes on its own completion event. The halt acknowledge is raised only once every slot is closed, and it stays high until the engine is restarted. While the sequencer drains or is halted, it tells the engine not to start executing a fetched instruction. For a memory-bound DMA interrupted by a SCSI-side event, it requests a FIFO flush. It aborts a fetch hit by a bus fault. It tells the engine to load the script pointer with the branch target when a phase-conditional jump or call completes.

Top module: `halt_seq`

## Requirements
- R1: `halt_ack_o` is a level that rises only after `irq_req_i` is sampled high while running. It stays high until `restart_i` is sampled high while halted, and it is low in the cycle after that restart.
- R2: A fetch in progress at the request (`fetch_busy_i`) delays the acknowledge until `fetch_done_i` is seen. `exec_hold_o` is high from the cycle after the request until the cycle after restart.
- R3: A `bus_fault_i` strobe while a fetch is being waited for ends that wait at once. It produces a single-cycle `fetch_abort_o` pulse in the following cycle.
- R4: When `dma_active_i`, `dma_to_mem_i` and `irq_scsi_i` are all high at the request, `flush_req_o` is high from the next cycle until `flush_done_i` is sampled. The acknowledge follows the flush.
- R5: Any other active DMA waits only for the current bus cycle, which means until `bus_cycle_busy_i` is low. This includes a write to memory with a non-SCSI source. No flush is requested in these cases.
- R6: A handshake in progress (`hs_busy_i`) delays the acknowledge until `hs_busy_i` is sampled low.
- R7: A nonzero `ofs_cnt_i` at the request delays the acknowledge until `ofs_cnt_i` is sampled zero.
- R8: A control-flow instruction in execution (`xctl_busy_i`) delays the acknowledge until `xctl_done_i`. With no activity at all, the acknowledge is high two cycles after the request cycle.
- R9: When a waited control-flow instruction completes with `xctl_phase_i` high, `ptr_load_tgt_o` pulses for one cycle, one cycle before the acknowledge can rise. No pulse occurs without `xctl_phase_i` or without a waited instruction.
- R10: With several conditions pending, the acknowledge rises one cycle after the last of them clears. Each condition stays pending until its own completion event.
- R11: `irq_req_i` while draining or halted, and `restart_i` while draining, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Halt request from an interrupt |
| irq_scsi_i | input | 1 | Request originates on the SCSI side |
| restart_i | input | 1 | Resume from halt |
| fetch_busy_i | input | 1 | Instruction fetch in progress |
| fetch_done_i | input | 1 | Fetch completion strobe |
| bus_fault_i | input | 1 | Bus fault strobe |
| xctl_busy_i | input | 1 | Control-flow instruction executing |
| xctl_done_i | input | 1 | Control-flow instruction completion strobe |
| xctl_phase_i | input | 1 | Current control-flow instruction is phase-conditional |
| dma_active_i | input | 1 | Data transfer in progress |
| dma_to_mem_i | input | 1 | Transfer direction is a write to memory |
| bus_cycle_busy_i | input | 1 | Current host bus cycle not finished |
| hs_busy_i | input | 1 | Request/acknowledge handshake begun and not finished |
| ofs_cnt_i | input | OFS_W | Outstanding synchronous offset |
| flush_done_i | input | 1 | FIFO flush completion strobe |
| halt_ack_o | output | 1 | Engine halted |
| exec_hold_o | output | 1 | Do not start execution of the fetched instruction |
| flush_req_o | output | 1 | Flush the DMA FIFO to memory |
| fetch_abort_o | output | 1 | Abort the faulted fetch |
| ptr_load_tgt_o | output | 1 | Load the script pointer with the branch target |

## Verification
The bench targets these corner cases:

- A completion event that arrives in the cycle right after the request. A design that samples it one cycle late would acknowledge late.
- Several overlapping conditions with different finishing times. A design that lets any single slot release the halt would acknowledge too early.
- A SCSI-sourced write to memory set against a write with a non-SCSI source. A design that decodes the flush case wrongly would either flush needlessly or drop buffered data.
- A bus fault during a fetch, and phase-conditional against plain control-flow completions. A broken pulse there would either abort with no fault or leave the pointer stale.
- Stray requests and restarts during draining. A design that does not ignore them would re-arm or release the halt early.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_HALT} seq_state_e;

  localparam int W_FETCH = 0;
  localparam int W_XCTL  = 1;
  localparam int W_FLUSH = 2;
  localparam int W_CYCLE = 3;
  localparam int W_HS    = 4;
  localparam int W_OFS   = 5;
  localparam int N_WAIT  = 6;
endpackage

// File: rtl/halt_need_decode.sv
module halt_need_decode
  import halt_seq_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic              irq_scsi_i,
  input  logic              fetch_busy_i,
  input  logic              fetch_done_i,
  input  logic              bus_fault_i,
  input  logic              xctl_busy_i,
  input  logic              xctl_done_i,
  input  logic              dma_active_i,
  input  logic              dma_to_mem_i,
  input  logic              bus_cycle_busy_i,
  input  logic              hs_busy_i,
  input  logic [OFS_W-1:0]  ofs_cnt_i,
  input  logic              flush_done_i,
  output logic [N_WAIT-1:0] need_o,
  output logic [N_WAIT-1:0] done_o
);
  logic flush_case;

  always_comb begin
    flush_case      = dma_active_i & dma_to_mem_i & irq_scsi_i;
    need_o          = '0;
    done_o          = '0;
    need_o[W_FETCH] = fetch_busy_i;
    done_o[W_FETCH] = fetch_done_i | bus_fault_i;  // fault cuts the fetch short
    need_o[W_XCTL]  = xctl_busy_i;
    done_o[W_XCTL]  = xctl_done_i;
    need_o[W_FLUSH] = flush_case;
    done_o[W_FLUSH] = flush_done_i;
    need_o[W_CYCLE] = dma_active_i & bus_cycle_busy_i & ~flush_case;
    done_o[W_CYCLE] = ~bus_cycle_busy_i;
    need_o[W_HS]    = hs_busy_i;
    done_o[W_HS]    = ~hs_busy_i;
    need_o[W_OFS]   = |ofs_cnt_i;
    done_o[W_OFS]   = ~|ofs_cnt_i;
  end
endmodule

// File: rtl/halt_wait_slot.sv
module halt_wait_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic need_i,
  input  logic done_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (capture_i) pend_d = need_i & ~done_i;
    else           pend_d = pend_q & ~done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_SLOT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !done_i |=> pend_q);  // R10
endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_seq_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_req_i,
  input  logic             irq_scsi_i,
  input  logic             restart_i,
  input  logic             fetch_busy_i,
  input  logic             fetch_done_i,
  input  logic             bus_fault_i,
  input  logic             xctl_busy_i,
  input  logic             xctl_done_i,
  input  logic             xctl_phase_i,
  input  logic             dma_active_i,
  input  logic             dma_to_mem_i,
  input  logic             bus_cycle_busy_i,
  input  logic             hs_busy_i,
  input  logic [OFS_W-1:0] ofs_cnt_i,
  input  logic             flush_done_i,
  output logic             halt_ack_o,
  output logic             exec_hold_o,
  output logic             flush_req_o,
  output logic             fetch_abort_o,
  output logic             ptr_load_tgt_o
);
  seq_state_e        state_q, state_d;
  logic [N_WAIT-1:0] need, done, pend;
  logic              capture, wait_fetch, wait_xctl;
  logic              abort_q, ptr_q;

  assign capture = (state_q == ST_RUN) & irq_req_i;

  halt_need_decode #(.OFS_W(OFS_W)) u_decode (
    .irq_scsi_i       (irq_scsi_i),
    .fetch_busy_i     (fetch_busy_i),
    .fetch_done_i     (fetch_done_i),
    .bus_fault_i      (bus_fault_i),
    .xctl_busy_i      (xctl_busy_i),
    .xctl_done_i      (xctl_done_i),
    .dma_active_i     (dma_active_i),
    .dma_to_mem_i     (dma_to_mem_i),
    .bus_cycle_busy_i (bus_cycle_busy_i),
    .hs_busy_i        (hs_busy_i),
    .ofs_cnt_i        (ofs_cnt_i),
    .flush_done_i     (flush_done_i),
    .need_o           (need),
    .done_o           (done)
  );

  for (genvar g = 0; g < N_WAIT; g++) begin : g_slot
    halt_wait_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture),
      .need_i    (need[g]),
      .done_i    (done[g]),
      .pend_o    (pend[g])
    );
  end

  // a slot is "being waited for" either at capture or while it is pending
  assign wait_fetch = capture ? need[W_FETCH] : pend[W_FETCH];
  assign wait_xctl  = capture ? need[W_XCTL]  : pend[W_XCTL];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (irq_req_i) state_d = ST_DRAIN;
      ST_DRAIN: if (pend == '0) state_d = ST_HALT;
      ST_HALT:  if (restart_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      abort_q <= 1'b0;
      ptr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= wait_fetch & bus_fault_i;
      ptr_q   <= wait_xctl & xctl_done_i & xctl_phase_i;
    end
  end

  assign halt_ack_o     = (state_q == ST_HALT);
  assign exec_hold_o    = (state_q != ST_RUN);
  assign flush_req_o    = pend[W_FLUSH];
  assign fetch_abort_o  = abort_q;
  assign ptr_load_tgt_o = ptr_q;

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_ack_o && !restart_i |=> halt_ack_o);  // R1
  AST_ACK_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_ack_o) |-> $past(pend == '0));  // R10
  AST_FLUSH_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> !halt_ack_o);  // R4
  AST_PTR_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_tgt_o |-> !halt_ack_o);  // R9
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_abort_o |=> !fetch_abort_o);  // R3
  AST_HOLD_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_hold_o && irq_req_i |=> exec_hold_o);  // R2
endmodule

// File: tb/halt_seq_test.sv
module halt_seq_test;
  localparam int OFS_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, irq_req_i, irq_scsi_i, restart_i, fetch_busy_i, fetch_done_i, bus_fault_i;
  logic xctl_busy_i, xctl_done_i, xctl_phase_i, dma_active_i, dma_to_mem_i;
  logic bus_cycle_busy_i, hs_busy_i, flush_done_i;
  logic [OFS_W-1:0] ofs_cnt_i;
  logic halt_ack_o, exec_hold_o, flush_req_o, fetch_abort_o, ptr_load_tgt_o;

  halt_seq #(.OFS_W(OFS_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req_i), .irq_scsi_i(irq_scsi_i),
    .restart_i(restart_i), .fetch_busy_i(fetch_busy_i), .fetch_done_i(fetch_done_i),
    .bus_fault_i(bus_fault_i), .xctl_busy_i(xctl_busy_i), .xctl_done_i(xctl_done_i),
    .xctl_phase_i(xctl_phase_i), .dma_active_i(dma_active_i), .dma_to_mem_i(dma_to_mem_i),
    .bus_cycle_busy_i(bus_cycle_busy_i), .hs_busy_i(hs_busy_i), .ofs_cnt_i(ofs_cnt_i),
    .flush_done_i(flush_done_i), .halt_ack_o(halt_ack_o), .exec_hold_o(exec_hold_o),
    .flush_req_o(flush_req_o), .fetch_abort_o(fetch_abort_o), .ptr_load_tgt_o(ptr_load_tgt_o)
  );

  int checks = 0;
  int fails  = 0;

  // scenario description
  bit f_fetch, f_fault, f_xctl, f_phase, f_dma, f_mem, f_scsi, f_cyc, f_hs, f_irq2, f_rst2;
  int f_ofs, d_fetch, d_xctl, d_flush, d_cyc, d_hs, d_ofs;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int max_delay(bit nf, bit nx, bit nfl, bit nc, bit nh, bit no);
    int m = 0;
    if (nf  && d_fetch > m) m = d_fetch;
    if (nx  && d_xctl  > m) m = d_xctl;
    if (nfl && d_flush > m) m = d_flush;
    if (nc  && d_cyc   > m) m = d_cyc;
    if (nh  && d_hs    > m) m = d_hs;
    if (no  && d_ofs   > m) m = d_ofs;
    return m;
  endfunction

  task automatic idle_inputs();
    irq_req_i = 0; irq_scsi_i = 0; restart_i = 0; fetch_busy_i = 0; fetch_done_i = 0;
    bus_fault_i = 0; xctl_busy_i = 0; xctl_done_i = 0; xctl_phase_i = 0; dma_active_i = 0;
    dma_to_mem_i = 0; bus_cycle_busy_i = 0; hs_busy_i = 0; ofs_cnt_i = '0; flush_done_i = 0;
  endtask

  task automatic clear_case();
    f_fetch = 0; f_fault = 0; f_xctl = 0; f_phase = 0; f_dma = 0; f_mem = 0; f_scsi = 0;
    f_cyc = 0; f_hs = 0; f_irq2 = 0; f_rst2 = 0; f_ofs = 0;
    d_fetch = 1; d_xctl = 1; d_flush = 1; d_cyc = 1; d_hs = 1; d_ofs = 1;
  endtask

  task automatic run_case(string tag);
    bit nf, nx, nfl, nc, nh, no;
    int dmax;
    nf  = f_fetch; nx = f_xctl; nfl = f_dma && f_mem && f_scsi;
    nc  = f_dma && f_cyc && !nfl; nh = f_hs; no = (f_ofs != 0);
    dmax = max_delay(nf, nx, nfl, nc, nh, no);
    @(negedge clk);
    fetch_busy_i = f_fetch; xctl_busy_i = f_xctl; xctl_phase_i = f_phase;
    dma_active_i = f_dma; dma_to_mem_i = f_mem; irq_scsi_i = f_scsi;
    bus_cycle_busy_i = f_cyc; hs_busy_i = f_hs; ofs_cnt_i = OFS_W'(f_ofs); irq_req_i = 1;
    for (int n = 1; n <= dmax + 3; n++) begin
      @(negedge clk);
      irq_req_i = (n == 1) && f_irq2;  // R11 stray request while draining
      restart_i = (n == 1) && f_rst2;  // R11 stray restart while draining
      chk(tag, halt_ack_o, n >= dmax + 2);
      chk("R2", exec_hold_o, 1'b1);
      chk("R4", flush_req_o, nfl && (n <= d_flush));
      chk("R3", fetch_abort_o, nf && f_fault && (n == d_fetch + 1));
      chk("R9", ptr_load_tgt_o, nx && f_phase && (n == d_xctl + 1));
      fetch_done_i = (n == d_fetch) && !f_fault;
      bus_fault_i  = (n == d_fetch) && f_fault;
      if (n == d_fetch) fetch_busy_i = 0;
      xctl_done_i  = (n == d_xctl);
      if (n == d_xctl) xctl_busy_i = 0;
      flush_done_i = (n == d_flush);
      if (n == d_cyc) bus_cycle_busy_i = 0;
      if (n == d_hs)  hs_busy_i = 0;
      if (n == d_ofs) ofs_cnt_i = '0;
    end
    @(negedge clk);
    idle_inputs();
    irq_req_i = 1; hs_busy_i = 1;  // request while halted
    @(negedge clk);
    idle_inputs();
    chk("R11", halt_ack_o, 1'b1);
    chk("R11", flush_req_o, 1'b0);
    restart_i = 1;
    @(negedge clk);
    restart_i = 0;
    chk("R1", halt_ack_o, 1'b0);
    chk("R2", exec_hold_o, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    clear_case();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", halt_ack_o, 1'b0);
    chk("R2", exec_hold_o, 1'b0);
    chk("R4", flush_req_o, 1'b0);
    chk("R3", fetch_abort_o, 1'b0);
    chk("R9", ptr_load_tgt_o, 1'b0);

    clear_case(); run_case("R8");                                         // nothing active
    clear_case(); f_fetch = 1; d_fetch = 1; run_case("R2");
    clear_case(); f_fetch = 1; d_fetch = 4; run_case("R2");
    clear_case(); f_fetch = 1; f_fault = 1; d_fetch = 2; run_case("R3");
    clear_case(); f_dma = 1; f_mem = 1; f_scsi = 1; f_cyc = 1; d_flush = 5; d_cyc = 1; run_case("R4");
    clear_case(); f_dma = 1; f_mem = 1; f_scsi = 0; f_cyc = 1; d_cyc = 3; d_flush = 1; run_case("R5");
    clear_case(); f_dma = 1; f_mem = 0; f_scsi = 1; f_cyc = 1; d_cyc = 2; run_case("R5");
    clear_case(); f_hs = 1; d_hs = 3; run_case("R6");
    clear_case(); f_ofs = 7; d_ofs = 4; run_case("R7");
    clear_case(); f_xctl = 1; f_phase = 1; d_xctl = 2; run_case("R9");
    clear_case(); f_xctl = 1; f_phase = 0; d_xctl = 3; run_case("R8");
    clear_case(); f_phase = 1; d_xctl = 1; run_case("R9");                // done with no waited instr
    clear_case(); f_fetch = 1; f_xctl = 1; f_phase = 1; f_hs = 1; f_ofs = 3;
    d_fetch = 2; d_xctl = 5; d_hs = 1; d_ofs = 3; f_irq2 = 1; f_rst2 = 1; run_case("R10");
    clear_case(); f_rst2 = 1; f_irq2 = 1; run_case("R11");

    void'($urandom(32'd7321));
    for (int i = 0; i < 80; i++) begin
      clear_case();
      f_fetch = $urandom % 2; f_fault = $urandom % 2; f_xctl = $urandom % 2;
      f_phase = $urandom % 2; f_dma = $urandom % 2; f_mem = $urandom % 2;
      f_scsi  = $urandom % 2; f_cyc = $urandom % 2; f_hs = $urandom % 2;
      f_irq2  = $urandom % 2; f_rst2 = $urandom % 2;
      f_ofs   = ($urandom % 2) ? int'($urandom % 31) + 1 : 0;
      d_fetch = $urandom % 6 + 1; d_xctl = $urandom % 6 + 1; d_flush = $urandom % 6 + 1;
      d_cyc   = $urandom % 6 + 1; d_hs   = $urandom % 6 + 1; d_ofs   = $urandom % 6 + 1;
      run_case("R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule